// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a 64-bit virtual address to its leaf page table entry. It walks a three-level radix tree held in physical memory, with 8 KB pages and a 10-bit index at each level. A single-cycle start strobe captures the virtual address and the root frame number. The walker then issues one 64-bit physical read per level on a plain request/response port. The read address is formed from the current table's frame number shifted left by 13, plus eight times the level's index. The next table's frame number comes from bits 63:32 of the entry just read, and bit 0 of each entry is its valid flag.

The walk ends after the third read, or earlier if a first- or second-level entry has its valid bit clear. In every case the entry that was read last is returned unchanged, together with the level at which the walk ended and a one-cycle done pulse. Permission checks, buffer insertion and any caching of intermediate entries belong to the caller. The controller is a Moore machine with these states: IDLE, L1_REQ, L1_WAIT, L2_REQ, L2_WAIT, L3_REQ, L3_WAIT and DONE.

Its transitions are:
- IDLE to L1_REQ when start is high.
- Each Lx_REQ to its Lx_WAIT unconditionally.
- L1_WAIT to L2_REQ, and L2_WAIT to L3_REQ, on a response whose bit 0 is set.
- L1_WAIT or L2_WAIT to DONE on a response whose bit 0 is clear.
- L3_WAIT to DONE on any response.
- DONE to IDLE unconditionally.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: busy_o, mem_req_o and done_o are low, entry_o is zero and level_o is zero.
- R2: A start accepted in IDLE raises mem_req_o in the next cycle with address (root_frame_i << 13) + 8 * vaddr_i[42:33], using the values captured at start.
- R3: The second read uses address (first entry bits 63:32 << 13) + 8 * vaddr[32:23].
- R4: The third read uses address (second entry bits 63:32 << 13) + 8 * vaddr[22:13]. Virtual address bits outside 42:13 never affect any address.
- R5: A first-level entry with bit 0 clear ends the walk: no further read is issued, entry_o equals that entry, and level_o is 1.
- R6: A second-level entry with bit 0 clear ends the walk with entry_o equal to that entry and level_o equal to 2.
- R7: After a third read, entry_o equals the third entry whatever its bit 0 holds, and level_o is 3.
- R8: mem_req_o is a single-cycle pulse. The next request comes only after mem_rsp_i has been seen in a wait state, and mem_addr_o stays stable while a read is outstanding.
- R9: start_i is ignored whenever busy_o is high, including the DONE cycle. Changes to vaddr_i and root_frame_i during a walk have no effect on it.
- R10: done_o pulses for exactly one cycle, in the cycle after the final response is sampled. entry_o and level_o then hold their values until the next walk ends, and busy_o falls after the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| vaddr_i | input | 64 | Virtual address to resolve |
| root_frame_i | input | 32 | Frame number of the first-level table |
| mem_req_o | output | 1 | Physical read request pulse |
| mem_addr_o | output | 64 | Physical byte address of the entry being read |
| mem_rsp_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Entry read from memory |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | Walk finished this cycle |
| entry_o | output | 64 | Last entry read by the walk |
| level_o | output | 2 | Level (1 to 3) at which the walk ended |

## Verification
Two events can share a cycle: the done pulse and a new start strobe. The bench raises start_i in exactly the DONE cycle of every walk. In the following cycle it requires busy_o and mem_req_o to be low and entry_o and level_o to be unchanged. The bench also holds start high and scrambles vaddr_i and root_frame_i during every wait window. It sweeps all four outcomes (end at level 1 or 2, leaf valid or invalid) against three response latencies and four address and root patterns, and computes every expected address from the shift-and-add rule.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_L3_REQ,
        ST_L3_WAIT,
        ST_DONE
    } walk_state_t;

    localparam int unsigned WALK_LEVELS = 3;
    localparam int unsigned LEVEL_W     = 2;

endpackage

// File: rtl/pt_walk_idx.sv
module pt_walk_idx #(
    parameter int unsigned IDX_W      = 10,
    parameter int unsigned LEVELS     = 3,
    parameter int unsigned LEVEL_W    = 2,
    localparam int unsigned FIELD_W   = IDX_W * LEVELS
) (
    input  logic [FIELD_W-1:0] va_field,
    input  logic [LEVEL_W-1:0] level,
    output logic [IDX_W-1:0]   idx
);

    logic [IDX_W-1:0] idx_arr [LEVELS];

    // level 1 uses the most significant slice, the last level the least
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign idx_arr[g] = va_field[(LEVELS-1-g)*IDX_W +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (32'(level) == i + 1) idx = idx_arr[i];
        end
    end

endmodule

// File: rtl/pt_walk_addr.sv
module pt_walk_addr #(
    parameter int unsigned FRAME_W    = 32,
    parameter int unsigned IDX_W      = 10,
    parameter int unsigned PAGE_SHIFT = 13,
    parameter int unsigned PA_W       = 64,
    parameter int unsigned ENTRY_LOG2 = 3
) (
    input  logic [FRAME_W-1:0] frame,
    input  logic [IDX_W-1:0]   idx,
    output logic [PA_W-1:0]    addr
);

    logic [PA_W-1:0] table_base;
    logic [PA_W-1:0] entry_off;

    assign table_base = PA_W'(frame) << PAGE_SHIFT;
    assign entry_off  = PA_W'(idx) << ENTRY_LOG2;
    assign addr       = table_base + entry_off;

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
    import pt_walk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               rsp_valid,
    input  logic               entry_valid,
    output logic               req,
    output logic               busy,
    output logic               done,
    output logic               accept,
    output logic               capture,
    output logic               descend,
    output logic [LEVEL_W-1:0] cur_level
);

    walk_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_L1_REQ;
            ST_L1_REQ:  state_d = ST_L1_WAIT;
            ST_L1_WAIT: if (rsp_valid) state_d = entry_valid ? ST_L2_REQ : ST_DONE;
            ST_L2_REQ:  state_d = ST_L2_WAIT;
            ST_L2_WAIT: if (rsp_valid) state_d = entry_valid ? ST_L3_REQ : ST_DONE;
            ST_L3_REQ:  state_d = ST_L3_WAIT;
            ST_L3_WAIT: if (rsp_valid) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req       = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        accept    = 1'b0;
        capture   = 1'b0;
        descend   = 1'b0;
        cur_level = '0;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            ST_L1_REQ: begin
                req       = 1'b1;
                cur_level = LEVEL_W'(1);
            end
            ST_L1_WAIT: begin
                cur_level = LEVEL_W'(1);
                capture   = rsp_valid;
                descend   = rsp_valid & entry_valid;
            end
            ST_L2_REQ: begin
                req       = 1'b1;
                cur_level = LEVEL_W'(2);
            end
            ST_L2_WAIT: begin
                cur_level = LEVEL_W'(2);
                capture   = rsp_valid;
                descend   = rsp_valid & entry_valid;
            end
            ST_L3_REQ: begin
                req       = 1'b1;
                cur_level = LEVEL_W'(3);
            end
            ST_L3_WAIT: begin
                cur_level = LEVEL_W'(3);
                capture   = rsp_valid;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int unsigned VA_W       = 64,
    parameter int unsigned DATA_W     = 64,
    parameter int unsigned PA_W       = 64,
    parameter int unsigned PAGE_SHIFT = 13,
    parameter int unsigned IDX_W      = 10,
    parameter int unsigned FRAME_LSB  = 32,
    parameter int unsigned VALID_BIT  = 0,
    localparam int unsigned FRAME_W   = DATA_W - FRAME_LSB,
    localparam int unsigned FIELD_W   = IDX_W * WALK_LEVELS,
    localparam int unsigned ENTRY_LOG2 = $clog2(DATA_W / 8)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [VA_W-1:0]    vaddr_i,
    input  logic [FRAME_W-1:0] root_frame_i,
    output logic               mem_req_o,
    output logic [PA_W-1:0]    mem_addr_o,
    input  logic               mem_rsp_i,
    input  logic [DATA_W-1:0]  mem_rdata_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [DATA_W-1:0]  entry_o,
    output logic [LEVEL_W-1:0] level_o
);

    logic               accept, capture, descend;
    logic [LEVEL_W-1:0] cur_level;
    logic [FIELD_W-1:0] va_q;
    logic [FRAME_W-1:0] frame_q;
    logic [IDX_W-1:0]   idx;
    logic [DATA_W-1:0]  entry_q;
    logic [LEVEL_W-1:0] level_q;

    pt_walk_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_i),
        .rsp_valid   (mem_rsp_i),
        .entry_valid (mem_rdata_i[VALID_BIT]),
        .req         (mem_req_o),
        .busy        (busy_o),
        .done        (done_o),
        .accept      (accept),
        .capture     (capture),
        .descend     (descend),
        .cur_level   (cur_level)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q    <= '0;
            frame_q <= '0;
            entry_q <= '0;
            level_q <= '0;
        end else begin
            if (accept) begin
                va_q    <= vaddr_i[PAGE_SHIFT +: FIELD_W];
                frame_q <= root_frame_i;
            end
            if (capture) begin
                entry_q <= mem_rdata_i;
                level_q <= cur_level;
            end
            if (descend) begin
                frame_q <= mem_rdata_i[DATA_W-1:FRAME_LSB];
            end
        end
    end

    pt_walk_idx #(
        .IDX_W   (IDX_W),
        .LEVELS  (WALK_LEVELS),
        .LEVEL_W (LEVEL_W)
    ) u_idx (
        .va_field (va_q),
        .level    (cur_level),
        .idx      (idx)
    );

    pt_walk_addr #(
        .FRAME_W    (FRAME_W),
        .IDX_W      (IDX_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .PA_W       (PA_W),
        .ENTRY_LOG2 (ENTRY_LOG2)
    ) u_addr (
        .frame (frame_q),
        .idx   (idx),
        .addr  (mem_addr_o)
    );

    assign entry_o = entry_q;
    assign level_o = level_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned PA_W    = 64,
    parameter int unsigned LEVEL_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_req_o,
    input logic [PA_W-1:0]    mem_addr_o,
    input logic               busy_o,
    input logic               done_o,
    input logic [DATA_W-1:0]  entry_o,
    input logic [LEVEL_W-1:0] level_o
);

    // R8
    req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    // R8
    addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> $stable(mem_addr_o));

    // R2
    req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[2:0] == 3'b000));

    // R2
    first_req_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> mem_req_o);

    // R10
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req_o && !done_o));

    // R5
    early_stop_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && level_o != LEVEL_W'(3)) |-> !entry_o[0]);

    // R7
    done_level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (level_o != '0));

endmodule

bind pt_walker pt_walker_chk #(
    .DATA_W  (DATA_W),
    .PA_W    (PA_W),
    .LEVEL_W (2)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .entry_o    (entry_o),
    .level_o    (level_o)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] vaddr_i = '0;
    logic [31:0] root_frame_i = '0;
    logic        mem_req_o;
    logic [63:0] mem_addr_o;
    logic        mem_rsp_i = 1'b0;
    logic [63:0] mem_rdata_i = '0;
    logic        busy_o, done_o;
    logic [63:0] entry_o;
    logic [1:0]  level_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pt_walker uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .vaddr_i      (vaddr_i),
        .root_frame_i (root_frame_i),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .mem_rsp_i    (mem_rsp_i),
        .mem_rdata_i  (mem_rdata_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .entry_o      (entry_o),
        .level_o      (level_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] gen_va(input int k);
        case (k)
            0: return 64'h0;
            1: return '1;
            default: return 64'hA5C3_1E0F_7B29_D481 ^ (64'(k) * 64'h0000_2468_ACE1_3579);
        endcase
    endfunction

    function automatic logic [31:0] gen_root(input int k);
        case (k)
            0: return 32'h0000_0001;
            1: return 32'hFFFF_FFFF;
            default: return 32'h0012_3400 + 32'(k * 977);
        endcase
    endfunction

    function automatic logic [63:0] ent_addr(input logic [31:0] fr, input logic [9:0] ix);
        return ({32'h0, fr} << 13) + ({54'h0, ix} << 3);
    endfunction

    // pat: 0 stops at level 1, 1 stops at level 2, 2 valid leaf, 3 invalid leaf
    task automatic do_walk(input logic [63:0] va, input logic [31:0] root,
                           input int lat, input int pat, input int seed);
        logic [63:0] ents [3];
        logic [9:0]  ix   [3];
        logic [31:0] fr;
        logic [63:0] exp_a;
        int          n;
        n = (pat == 0) ? 1 : (pat == 1) ? 2 : 3;
        ix[0] = va[42:33];
        ix[1] = va[32:23];
        ix[2] = va[22:13];
        for (int j = 0; j < 3; j++) begin
            logic [31:0] hi, lo;
            hi = 32'h0004_0000 + 32'(seed * 131 + j * 7919);
            lo = 32'hC0DE_0000 ^ 32'(seed * 4 + j * 2);
            if (j == 2) hi = 32'hFFFF_0000 ^ 32'(seed);
            if (j == 0) lo[0] = (pat >= 1);
            if (j == 1) lo[0] = (pat >= 2);
            if (j == 2) lo[0] = (pat == 2);
            ents[j] = {hi, lo};
        end
        @(negedge clk);
        vaddr_i = va;
        root_frame_i = root;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        fr = root;
        for (int lv = 0; lv < n; lv++) begin
            exp_a = ent_addr(fr, ix[lv]);
            chk(mem_req_o === 1'b1, "R8 request pulse", 64'(mem_req_o), 64'd1);
            if (lv == 0) chk(mem_addr_o === exp_a, "R2 level1 address", mem_addr_o, exp_a);
            if (lv == 1) chk(mem_addr_o === exp_a, "R3 level2 address", mem_addr_o, exp_a);
            if (lv == 2) chk(mem_addr_o === exp_a, "R4 level3 address", mem_addr_o, exp_a);
            @(negedge clk);
            // R9: start held and inputs scrambled while a read is outstanding
            start_i = 1'b1;
            vaddr_i = ~va;
            root_frame_i = ~root;
            mem_rdata_i = ~ents[lv];
            chk(mem_req_o === 1'b0, "R8 no second request", 64'(mem_req_o), 64'd0);
            for (int w = 0; w < lat; w++) begin
                @(negedge clk);
                chk(mem_req_o === 1'b0 && mem_addr_o === exp_a, "R8 wait quiet",
                    mem_addr_o, exp_a);
            end
            mem_rsp_i = 1'b1;
            mem_rdata_i = ents[lv];
            @(negedge clk);
            mem_rsp_i = 1'b0;
            mem_rdata_i = ents[lv] ^ 64'hFFFF;
            start_i = 1'b0;
            fr = ents[lv][63:32];
        end
        chk(done_o === 1'b1 && mem_req_o === 1'b0, "R10 done pulse", 64'(done_o), 64'd1);
        chk(entry_o === ents[n-1], (n == 1) ? "R5 entry" : (n == 2) ? "R6 entry" : "R7 entry",
            entry_o, ents[n-1]);
        chk(level_o === 2'(n), (n == 1) ? "R5 level" : (n == 2) ? "R6 level" : "R7 level",
            64'(level_o), 64'(n));
        // R9: start in the DONE cycle is ignored
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o === 1'b0 && mem_req_o === 1'b0 && done_o === 1'b0,
            "R9 start in done ignored", {61'h0, busy_o, mem_req_o, done_o}, 64'h0);
        chk(entry_o === ents[n-1] && level_o === 2'(n), "R10 result held", entry_o, ents[n-1]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o === 1'b0 && mem_req_o === 1'b0 && done_o === 1'b0, "R1 reset outputs",
            {61'h0, busy_o, mem_req_o, done_o}, 64'h0);
        chk(entry_o === 64'h0 && level_o === 2'd0, "R1 reset result", entry_o, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 4; k++)
            for (int p = 0; p < 4; p++)
                for (int l = 0; l < 3; l++)
                    do_walk(gen_va(k), gen_root(k), l, p, k * 16 + p * 4 + l);
        // R4: bits outside 42:13 do not move any address
        do_walk(64'hFFE0_0000_0000_1FFF | 64'h0000_0246_8AC0_0000, 32'h0000_0777, 1, 2, 99);
        do_walk(64'h0000_0246_8AC0_0000, 32'h0000_0777, 0, 2, 99);
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule